// File: doc/BRIEF.md
# Programmable Telecom Frame Pulse Generator

The block derives a periodic frame pulse from a synthesized output clock. It counts cycles of that clock and opens a new frame every `cfg_period` cycles. At the start of each frame it drives an active pulse of `cfg_width` cycles on `fp_out`, in the polarity chosen by `cfg_invert`. A one-cycle `frame_stb` marks the first cycle of every frame. Every output is a flop on the rising edge of `clk`, so each pulse edge falls on a clock edge.

The period, width and polarity inputs are copied into working copies only when a frame ends. A change made in the middle of a frame therefore never shortens or stretches the pulse in progress. Out of reset the working copies hold the default setting, an 8 kHz frame from a 19.44 MHz clock. The counter range also covers a 2 kHz frame, four times the default period.

An external frame reference may realign the frame. When `cfg_sync_en` is set, the reference first passes through a synchronizer. A detected leading edge then restarts the frame, and the restart shows on the outputs a fixed number of cycles later. The reference may be a square clock, in which case only its rising edge counts. It may instead be a narrow pulse of either polarity.

Top module: `fpulse_gen`

## Requirements
- R1: While `rst_n` is low, `fp_out` is 0 and `frame_stb` is 0 (the default polarity is active-high).
- R2: In the first cycle after reset is released, `frame_stb` is 1. The first frame uses the defaults: a period of 2430 cycles and a width of 1 cycle, whatever the configuration inputs hold.
- R3: Each frame lasts exactly the configured period in clock cycles, for any period up to at least four times the default (9720). `frame_stb` is high only in the first cycle of each frame.
- R4: `fp_out` is in its active level for exactly the configured width, starting in the cycle where `frame_stb` is high.
- R5: With `cfg_invert` = 1, the active level of `fp_out` is 0 and the idle level is 1. With `cfg_invert` = 0, the active level is 1.
- R6: A period below 2 is treated as 2. A width of 0 is treated as 1, and a width at or above the period is treated as the period minus 1.
- R7: The configuration inputs are sampled only at the clock edge that ends a frame. Changes made during a frame do not alter that frame's period, width or polarity.
- R8: With `cfg_sync_en` = 1, a qualifying sync edge restarts the frame and loads the configuration. Let the sync level first be captured at clock edge P. Then `frame_stb` and the active pulse start in the cycle after edge P+3.
- R9: With `cfg_sync_fmt` = 0 (square clock), only a rising edge of `sync_in` qualifies, whatever the value of `cfg_sync_neg`.
- R10: With `cfg_sync_fmt` = 1 (narrow pulse), the leading edge qualifies. That is the falling edge when `cfg_sync_neg` = 1 and the rising edge when `cfg_sync_neg` = 0; the opposite edge is ignored.
- R11: With `cfg_sync_en` = 0, no edge of `sync_in` changes the frame timing.
- R12: A sync level held after its leading edge causes no further restart. The following frame runs for the full configured period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized output clock that the frame is counted in |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_period | input | CNT_W | Frame period in clock cycles |
| cfg_width | input | CNT_W | Active pulse width in clock cycles |
| cfg_invert | input | 1 | 1 selects an active-low pulse |
| cfg_sync_en | input | 1 | Enables realignment to `sync_in` |
| cfg_sync_fmt | input | 1 | 0: square clock reference, 1: narrow pulse reference |
| cfg_sync_neg | input | 1 | In pulse format, 1 means the reference pulse is active low |
| sync_in | input | 1 | External frame reference, asynchronous |
| fp_out | output | 1 | Frame pulse |
| frame_stb | output | 1 | One-cycle marker of the first cycle of each frame |

## Verification
The assertions allow the configuration inputs to change in any cycle. They assume that `sync_in` stays at each level for longer than the synchronizer depth, so that each edge reaches the edge detector as a clean step. The stimulus changes every input at falling clock edges only. It holds each sync level for a whole frame or more, and it places sync edges well away from the natural frame boundary. This keeps a restart caused by the reference distinguishable from a normal wrap.

// File: rtl/fpg_pkg.sv
// Shared definitions for the frame pulse generator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fpg_pkg;

    // Reference format selector
    typedef enum logic {
        SYNC_FMT_CLOCK = 1'b0,
        SYNC_FMT_PULSE = 1'b1
    } sync_fmt_e;

    // Shortest frame the counter will run
    localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/fpg_sync_edge.sv
// Brings the asynchronous frame reference into the clock domain and
// reports a single-cycle hit on its qualifying leading edge.
// Assumes the reference holds each level longer than STAGES cycles.
module fpg_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic fmt_sel,
    input  logic neg_lead,
    input  logic enable,
    output logic hit
);
    import fpg_pkg::*;

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sq;
    logic              lvl_prev;
    logic              rise;
    logic              fall;
    logic              use_fall;

    // Synchronizer chain; the depth parameter picks the shift form
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sq <= '0;
                else        sq <= sync_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sq <= '0;
                else        sq <= {sq[STAGES-2:0], sync_in};
            end
        end
    endgenerate

    // Previous synchronized level, kept even while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= sq[LAST];
    end

    // Leading-edge selection by format and pulse polarity
    always_comb begin
        rise     = sq[LAST] & ~lvl_prev;
        fall     = ~sq[LAST] & lvl_prev;
        use_fall = (sync_fmt_e'(fmt_sel) == SYNC_FMT_PULSE) && neg_lead;
        hit      = enable & (use_fall ? fall : rise);
    end

endmodule

// File: rtl/fpg_cfg_shadow.sv
// Working copy of period, width and polarity, loaded only at a frame
// boundary. Clamps the values into a legal range as they are loaded.
// Assumes load is high for one cycle per boundary.
module fpg_cfg_shadow #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DEF_PERIOD = 2430,
    parameter int unsigned DEF_WIDTH  = 1,
    parameter bit          DEF_INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_invert,
    output logic [CNT_W-1:0] per_s,
    output logic [CNT_W-1:0] wid_s,
    output logic             inv_s
);
    import fpg_pkg::*;

    localparam logic [CNT_W-1:0] P_MIN = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] P_DEF = CNT_W'(DEF_PERIOD);
    localparam logic [CNT_W-1:0] W_DEF = CNT_W'(DEF_WIDTH);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] per_c;
    logic [CNT_W-1:0] wid_c;

    // Clamp requested values into the legal range
    always_comb begin
        per_c = (cfg_period < P_MIN) ? P_MIN : cfg_period;
        if (cfg_width == '0)
            wid_c = ONE;
        else if (cfg_width >= per_c)
            wid_c = per_c - ONE;
        else
            wid_c = cfg_width;
    end

    // Load the clamped setting at each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_s <= P_DEF;
            wid_s <= W_DEF;
            inv_s <= DEF_INVERT;
        end else if (load) begin
            per_s <= per_c;
            wid_s <= wid_c;
            inv_s <= cfg_invert;
        end
    end

endmodule

// File: rtl/fpg_frame_ctr.sv
// Frame position counter. It runs from 0 to period-1 and restarts either
// on the natural wrap or on a sync hit.
// Assumes per_s is at least 2.
module fpg_frame_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] per_s,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt,
    output logic             restart
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Frame ends at the last position or on an external realignment
    always_comb begin
        restart = hit | (cnt >= per_s - ONE);
    end

    // Advance or restart the frame position
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + ONE;
    end

endmodule

// File: rtl/fpg_pulse_shaper.sv
// Turns the frame position into a registered pulse of the programmed
// width and polarity, plus a registered first-cycle strobe.
// Assumes wid_s is between 1 and period-1.
module fpg_pulse_shaper #(
    parameter int unsigned CNT_W      = 16,
    parameter bit          DEF_INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] wid_s,
    input  logic             inv_s,
    output logic             fp_out,
    output logic             frame_stb
);
    logic active;

    // Active while inside the programmed width
    always_comb begin
        active = (cnt < wid_s);
    end

    // Register the shaped pulse and the frame-start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_out    <= DEF_INVERT;
            frame_stb <= 1'b0;
        end else begin
            fp_out    <= active ^ inv_s;
            frame_stb <= (cnt == '0);
        end
    end

endmodule

// File: rtl/fpulse_gen.sv
// Top of the telecom frame pulse generator. It ties the reference edge
// detector, the configuration shadow, the frame counter and the pulse
// shaper together. The defaults give an 8 kHz frame from 19.44 MHz.
// Assumes clk is the synthesized clock the pulse must align to.
module fpulse_gen #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DEF_PERIOD  = 2430,
    parameter int unsigned DEF_WIDTH   = 1,
    parameter bit          DEF_INVERT  = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_invert,
    input  logic             cfg_sync_en,
    input  logic             cfg_sync_fmt,
    input  logic             cfg_sync_neg,
    input  logic             sync_in,
    output logic             fp_out,
    output logic             frame_stb
);
    logic             sync_hit;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_s;
    logic [CNT_W-1:0] wid_s;
    logic             inv_s;

    // Reference synchronizer and edge qualifier
    fpg_sync_edge #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .fmt_sel  (cfg_sync_fmt),
        .neg_lead (cfg_sync_neg),
        .enable   (cfg_sync_en),
        .hit      (sync_hit)
    );

    // Boundary-loaded configuration
    fpg_cfg_shadow #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_WIDTH  (DEF_WIDTH),
        .DEF_INVERT (DEF_INVERT)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (restart),
        .cfg_period (cfg_period),
        .cfg_width  (cfg_width),
        .cfg_invert (cfg_invert),
        .per_s      (per_s),
        .wid_s      (wid_s),
        .inv_s      (inv_s)
    );

    // Frame position
    fpg_frame_ctr #(
        .CNT_W   (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_s   (per_s),
        .hit     (sync_hit),
        .cnt     (cnt),
        .restart (restart)
    );

    // Output pulse and strobe
    fpg_pulse_shaper #(
        .CNT_W      (CNT_W),
        .DEF_INVERT (DEF_INVERT)
    ) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .wid_s      (wid_s),
        .inv_s      (inv_s),
        .fp_out     (fp_out),
        .frame_stb  (frame_stb)
    );

endmodule

// File: rtl/fpulse_gen_chk.sv
// Property checker for fpulse_gen, attached by bind. It watches the
// ports together with the signals that pass between the submodules.
module fpulse_gen_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_sync_en,
    input logic             fp_out,
    input logic             frame_stb,
    input logic             sync_hit,
    input logic             restart,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_s,
    input logic [CNT_W-1:0] wid_s,
    input logic             inv_s
);
    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per_s);

    // R6
    width_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_s != '0) && (wid_s < per_s));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(restart) |-> $stable({per_s, wid_s, inv_s}));

    // R4
    stb_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (fp_out != $past(inv_s)));

    // R8
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> (cnt == '0));

    // R11
    sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sync_en |-> !sync_hit);

endmodule

bind fpulse_gen fpulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sync_en (cfg_sync_en),
    .fp_out      (fp_out),
    .frame_stb   (frame_stb),
    .sync_hit    (sync_hit),
    .restart     (restart),
    .cnt         (cnt),
    .per_s       (per_s),
    .wid_s       (wid_s),
    .inv_s       (inv_s)
);

// File: tb/fpulse_gen_tb_top.sv
`timescale 1ns/1ps
// Directed bench for fpulse_gen: one task per scenario.
module fpulse_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd20;
    logic [15:0] cfg_width = 16'd4;
    logic        cfg_invert = 1'b0;
    logic        cfg_sync_en = 1'b0;
    logic        cfg_sync_fmt = 1'b0;
    logic        cfg_sync_neg = 1'b0;
    logic        sync_in = 1'b0;
    logic        fp_out;
    logic        frame_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int cur_per = 2430;
    int cur_wid = 1;
    bit cur_inv = 1'b0;

    always #2 clk = ~clk;

    fpulse_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_period   (cfg_period),
        .cfg_width    (cfg_width),
        .cfg_invert   (cfg_invert),
        .cfg_sync_en  (cfg_sync_en),
        .cfg_sync_fmt (cfg_sync_fmt),
        .cfg_sync_neg (cfg_sync_neg),
        .sync_in      (sync_in),
        .fp_out       (fp_out),
        .frame_stb    (frame_stb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Measure one frame; entry and exit at a falling edge showing the strobe
    task automatic grab(input bit inv, output int per, output int wid);
        per = 0;
        wid = 0;
        do begin
            if (fp_out != inv) wid++;
            per++;
            @(negedge clk);
        end while (!frame_stb && per < 20000);
    endtask

    // Set a new configuration at a strobe, verify old then new frame
    task automatic apply(input int per, input int wid, input bit inv,
                         input int eper, input int ewid, input string rq);
        int p, w;
        cfg_period = 16'(per);
        cfg_width  = 16'(wid);
        cfg_invert = inv;
        grab(cur_inv, p, w);
        check(p == cur_per, "R7", "old frame period", p, cur_per);
        check(w == cur_wid, "R7", "old frame width", w, cur_wid);
        grab(inv, p, w);
        check(p == eper, rq, "frame period", p, eper);
        check(w == ewid, rq, "pulse width", w, ewid);
        cur_per = eper;
        cur_wid = ewid;
        cur_inv = inv;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(fp_out == 1'b0, "R1", "fp_out in reset", int'(fp_out), 0);
        check(frame_stb == 1'b0, "R1", "frame_stb in reset", int'(frame_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_default_frame();
        int p, w;
        check(frame_stb == 1'b1, "R2", "strobe after release", int'(frame_stb), 1);
        grab(1'b0, p, w);
        check(p == 2430, "R2", "default period", p, 2430);
        check(w == 1, "R2", "default width", w, 1);
        grab(1'b0, p, w);
        check(p == 20, "R3", "first loaded period", p, 20);
        check(w == 4, "R4", "first loaded width", w, 4);
        cur_per = 20;
        cur_wid = 4;
        cur_inv = 1'b0;
    endtask

    task automatic t_period_width();
        apply(30, 7, 1'b0, 30, 7, "R3");
        apply(9, 1, 1'b0, 9, 1, "R4");
        apply(64, 63, 1'b0, 64, 63, "R4");
        apply(9720, 16, 1'b0, 9720, 16, "R3");
    endtask

    task automatic t_polarity();
        apply(12, 3, 1'b1, 12, 3, "R5");
        check(fp_out == 1'b0, "R5", "active-low level at strobe", int'(fp_out), 0);
        apply(12, 3, 1'b0, 12, 3, "R5");
    endtask

    task automatic t_clamp();
        apply(1, 0, 1'b0, 2, 1, "R6");
        apply(6, 9, 1'b0, 6, 5, "R6");
    endtask

    task automatic t_midframe();
        int n, p, w;
        apply(40, 10, 1'b0, 40, 10, "R7");
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        cfg_period = 16'd17; cfg_width = 16'd2; cfg_invert = 1'b1;
        repeat (5) begin @(negedge clk); n++; end
        cfg_period = 16'd24; cfg_width = 16'd6; cfg_invert = 1'b0;
        while (!frame_stb && n < 20000) begin @(negedge clk); n++; end
        check(n == 40, "R7", "frame with mid-frame edits", n, 40);
        grab(1'b0, p, w);
        check(p == 24, "R7", "period after boundary", p, 24);
        check(w == 6, "R7", "width after boundary", w, 6);
        cur_per = 24;
        cur_wid = 6;
    endtask

    // Drive one sync level mid-frame and measure the distance to the next strobe
    task automatic sync_probe(input bit lvl, input bit exp_hit, input string rq);
        int n, p, w, exp_n;
        n = 0;
        repeat (10) begin @(negedge clk); n++; end
        sync_in = lvl;
        while (!frame_stb && n < 20000) begin @(negedge clk); n++; end
        exp_n = exp_hit ? 14 : 50;
        check(n == exp_n, rq, "cycles to next strobe", n, exp_n);
        if (exp_hit)
            check(fp_out == 1'b1, rq, "pulse active at realigned start", int'(fp_out), 1);
        grab(1'b0, p, w);
        check(p == 50, exp_hit ? "R12" : rq, "frame after sync edge", p, 50);
    endtask

    task automatic t_sync();
        apply(50, 5, 1'b0, 50, 5, "R3");
        cfg_sync_en = 1'b0;
        sync_probe(1'b1, 1'b0, "R11");
        sync_probe(1'b0, 1'b0, "R11");
        cfg_sync_en = 1'b1; cfg_sync_fmt = 1'b0; cfg_sync_neg = 1'b1;
        sync_probe(1'b1, 1'b1, "R9");
        sync_probe(1'b0, 1'b0, "R9");
        cfg_sync_fmt = 1'b1; cfg_sync_neg = 1'b1;
        sync_probe(1'b1, 1'b0, "R10");
        sync_probe(1'b0, 1'b1, "R10");
        cfg_sync_neg = 1'b0;
        sync_probe(1'b1, 1'b1, "R8");
        sync_probe(1'b0, 1'b0, "R10");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_default_frame();
        t_period_width();
        t_polarity();
        t_clamp();
        t_midframe();
        t_sync();
        finish_run();
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule